// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for fixed-point load and store operations. It takes a base register number and value, an index register value, a raw 16-bit immediate and a two-bit addressing-form selector. From these it produces a 64-bit effective address as the base plus an offset. The offset is one of four things: a sign-extended 16-bit displacement, a displacement whose low two bits are forced to zero, a displacement whose low four bits are forced to zero, or the full index register value.

The block also decides whether the base register is written back with the new address, as update-form operations require. It flags update-form loads whose register fields are illegal, and an illegal operation never writes back.

The result appears one clock after the inputs by default. A parameter removes the output register and makes the block purely combinational. Memory access and load-data formatting belong to other blocks.

Top module: `ea_agen`

## Requirements
- R1: For a non-update operation (`upd`=0) with `base_idx`=0, the base operand is the constant 0 and `base_val` is ignored. In every other case the base operand is `base_val`.
- R2: With `form`=0 (16-bit displacement), the offset is `imm_raw` sign-extended from bit 15 to 64 bits.
- R3: With `form`=1 (word-scaled displacement), `imm_raw[1:0]` is ignored. The offset is `{imm_raw[15:2],2'b00}` sign-extended from bit 15.
- R4: With `form`=2 (16-byte-scaled displacement), `imm_raw[3:0]` is ignored. The offset is `{imm_raw[15:4],4'b0000}` sign-extended from bit 15.
- R5: With `form`=3 (indexed), the offset is `index_val` and `imm_raw` is ignored.
- R6: An update operation (`upd`=1) always takes `base_val` as its base, even when `base_idx`=0. It asserts `wb_en` when it is not flagged invalid and `base_idx`≠0. `wb_idx` always equals the `base_idx` of the same operation.
- R7: A load update (`upd`=1, `is_store`=0) with `base_idx`=0 or `base_idx`=`rt_idx` sets `bad_form` and forces `wb_en` to 0. `bad_form` is 0 in all other cases.
- R8: A store update (`is_store`=1) with `rt_idx`=`base_idx`≠0 is legal: `bad_form`=0 and `wb_en`=1.
- R9: The address is (base + offset) mod 2^64, and no overflow is reported.
- R10: With `OUT_REG`=1 (the default), outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_idx | input | 5 | Base register number |
| base_val | input | 64 | Base register contents |
| index_val | input | 64 | Index register contents |
| imm_raw | input | 16 | Raw immediate field |
| form | input | 2 | Addressing form: 0 disp, 1 word-scaled, 2 16-byte-scaled, 3 indexed |
| upd | input | 1 | Update-form operation |
| rt_idx | input | 5 | Target (load) or source (store) register number |
| is_store | input | 1 | 1 for store, 0 for load |
| ea_out | output | 64 | Effective address |
| wb_en | output | 1 | Write the address back to the base register |
| wb_idx | output | 5 | Register number for the write-back |
| bad_form | output | 1 | Illegal update-form load |

## Verification
The checker tests the write-back and invalid-form rules on every cycle against the inputs of the previous cycle. It confirms that a flagged operation never writes back, that non-update operations never write back, and that legal store updates write back to the base register. It also checks two address rules each cycle: a zero base with the indexed form yields exactly the index value, and the 16-byte-scaled form with a zero base yields an aligned address. Sign extension across each form, ignored low immediate bits, the update base that holds a register-0 value, and modular wrap-around are shown only by the bench's directed and random scenarios against its reference model.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    FM_DISP   = 2'd0,
    FM_DISP_W = 2'd1,
    FM_DISP_Q = 2'd2,
    FM_INDEX  = 2'd3
  } fm_t;
endpackage

// File: rtl/ea_base_pick.sv
module ea_base_pick #(
  parameter int XLEN = 64,
  parameter int REGW = 5
) (
  input  logic [REGW-1:0] base_idx,
  input  logic [XLEN-1:0] base_val,
  input  logic            upd,
  output logic [XLEN-1:0] base_op
);
  // Register zero reads as literal zero only for non-update operations (R1, R6)
  always_comb begin
    if (!upd && (base_idx == '0)) base_op = '0;
    else                          base_op = base_val;
  end
endmodule

// File: rtl/ea_offset_gen.sv
module ea_offset_gen #(
  parameter int XLEN = 64,
  parameter int IMMW = 16,
  parameter int WSH  = 2,
  parameter int QSH  = 4
) (
  input  logic [1:0]      form,
  input  logic [IMMW-1:0] imm_raw,
  input  logic [XLEN-1:0] index_val,
  output logic [XLEN-1:0] offset
);
  import ea_pkg::*;
  localparam int EXTW = XLEN - IMMW;

  logic [IMMW-1:0] imm_w, imm_q;
  assign imm_w = {imm_raw[IMMW-1:WSH], {WSH{1'b0}}};
  assign imm_q = {imm_raw[IMMW-1:QSH], {QSH{1'b0}}};

  always_comb begin
    unique case (fm_t'(form))
      FM_DISP:   offset = {{EXTW{imm_raw[IMMW-1]}}, imm_raw};
      FM_DISP_W: offset = {{EXTW{imm_w[IMMW-1]}}, imm_w};
      FM_DISP_Q: offset = {{EXTW{imm_q[IMMW-1]}}, imm_q};
      default:   offset = index_val;
    endcase
  end
endmodule

// File: rtl/ea_wb_ctrl.sv
module ea_wb_ctrl #(
  parameter int REGW = 5
) (
  input  logic [REGW-1:0] base_idx,
  input  logic [REGW-1:0] rt_idx,
  input  logic            upd,
  input  logic            is_store,
  output logic            wb_en,
  output logic            bad_form
);
  logic zero_base;
  assign zero_base = (base_idx == '0);
  // Loads may not update register zero or their own target; stores may
  always_comb begin
    bad_form = upd && !is_store && (zero_base || (base_idx == rt_idx));
    wb_en    = upd && !bad_form && !zero_base;
  end
endmodule

// File: rtl/ea_agen.sv
module ea_agen #(
  parameter int XLEN    = 64,
  parameter int REGW    = 5,
  parameter int IMMW    = 16,
  parameter int WSH     = 2,
  parameter int QSH     = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [REGW-1:0] base_idx,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  input  logic [IMMW-1:0] imm_raw,
  input  logic [1:0]      form,
  input  logic            upd,
  input  logic [REGW-1:0] rt_idx,
  input  logic            is_store,
  output logic [XLEN-1:0] ea_out,
  output logic            wb_en,
  output logic [REGW-1:0] wb_idx,
  output logic            bad_form
);
  logic [XLEN-1:0] base_op, offset, ea_c;
  logic            wb_c, bad_c;

  ea_base_pick #(.XLEN(XLEN), .REGW(REGW)) u_base (
    .base_idx(base_idx), .base_val(base_val), .upd(upd), .base_op(base_op)
  );

  ea_offset_gen #(.XLEN(XLEN), .IMMW(IMMW), .WSH(WSH), .QSH(QSH)) u_off (
    .form(form), .imm_raw(imm_raw), .index_val(index_val), .offset(offset)
  );

  ea_wb_ctrl #(.REGW(REGW)) u_wb (
    .base_idx(base_idx), .rt_idx(rt_idx), .upd(upd), .is_store(is_store),
    .wb_en(wb_c), .bad_form(bad_c)
  );

  // Plain modular add, carry out discarded (R9)
  assign ea_c = base_op + offset;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          ea_out   <= '0;
          wb_en    <= 1'b0;
          wb_idx   <= '0;
          bad_form <= 1'b0;
        end else begin
          ea_out   <= ea_c;
          wb_en    <= wb_c;
          wb_idx   <= base_idx;
          bad_form <= bad_c;
        end
      end
    end else begin : g_comb
      assign ea_out   = ea_c;
      assign wb_en    = wb_c;
      assign wb_idx   = base_idx;
      assign bad_form = bad_c;
    end
  endgenerate
endmodule

// File: rtl/ea_agen_chk.sv
module ea_agen_chk #(
  parameter int XLEN    = 64,
  parameter int REGW    = 5,
  parameter int IMMW    = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic [REGW-1:0] base_idx,
  input logic [XLEN-1:0] base_val,
  input logic [XLEN-1:0] index_val,
  input logic [IMMW-1:0] imm_raw,
  input logic [1:0]      form,
  input logic            upd,
  input logic [REGW-1:0] rt_idx,
  input logic            is_store,
  input logic [XLEN-1:0] ea_out,
  input logic            wb_en,
  input logic [REGW-1:0] wb_idx,
  input logic            bad_form
);
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  // R7: an illegal operation never writes back
  assert_bad_no_wb_R7: assert property (@(posedge clk) disable iff (rst)
    bad_form |-> !wb_en);

  // R6: a write-back never targets register zero
  assert_wb_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_idx != '0));

  generate
    if (OUT_REG) begin : g_seq
      // R7: illegal load update flagged one cycle later
      assert_load_upd_bad_R7: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(upd && !is_store && ((base_idx == '0) || (base_idx == rt_idx))) |-> bad_form);

      // R6: non-update operations never write back
      assert_no_upd_no_wb_R6: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(!upd) |-> (!wb_en && !bad_form));

      // R8: store update with nonzero base writes back to that base
      assert_store_upd_wb_R8: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(upd && is_store && (base_idx != '0)) |-> (wb_en && (wb_idx == $past(base_idx))));

      // R5: zero base, indexed form yields the index value
      assert_index_only_R5: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(!upd && (base_idx == '0) && (form == 2'd3)) |-> (ea_out == $past(index_val)));

      // R4: zero base, 16-byte-scaled form yields an aligned address
      assert_quad_align_R4: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(!upd && (base_idx == '0) && (form == 2'd2)) |-> (ea_out[3:0] == 4'd0));
    end
  endgenerate
endmodule

bind ea_agen ea_agen_chk #(.XLEN(XLEN), .REGW(REGW), .IMMW(IMMW), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .base_idx(base_idx), .base_val(base_val), .index_val(index_val),
  .imm_raw(imm_raw), .form(form), .upd(upd), .rt_idx(rt_idx), .is_store(is_store),
  .ea_out(ea_out), .wb_en(wb_en), .wb_idx(wb_idx), .bad_form(bad_form)
);

// File: tb/tb_ea_agen.sv
`timescale 1ns/1ps
module tb_ea_agen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  base_idx = '0;
  logic [63:0] base_val = '0;
  logic [63:0] index_val = '0;
  logic [15:0] imm_raw = '0;
  logic [1:0]  form = '0;
  logic        upd = 1'b0;
  logic [4:0]  rt_idx = '0;
  logic        is_store = 1'b0;
  logic [63:0] ea_out;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic        bad_form;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ea_agen dut (
    .clk(clk), .rst(rst), .base_idx(base_idx), .base_val(base_val),
    .index_val(index_val), .imm_raw(imm_raw), .form(form), .upd(upd),
    .rt_idx(rt_idx), .is_store(is_store), .ea_out(ea_out), .wb_en(wb_en),
    .wb_idx(wb_idx), .bad_form(bad_form)
  );

  typedef struct {
    string       tag;
    logic [63:0] ea;
    logic        wb;
    logic [4:0]  wi;
    logic        bad;
  } exp_t;

  exp_t exp_q[$];

  function automatic exp_t model(string tag, logic [4:0] bi, logic [63:0] bv,
                                 logic [63:0] iv, logic [15:0] im, logic [1:0] fm,
                                 logic u, logic [4:0] rt, logic st);
    exp_t e;
    longint b, o;
    b = (!u && bi == 0) ? 0 : longint'(bv);
    case (fm)
      2'd0: o = longint'(shortint'(im));
      2'd1: o = longint'(shortint'(im & 16'hFFFC));
      2'd2: o = longint'(shortint'(im & 16'hFFF0));
      default: o = longint'(iv);
    endcase
    e.tag = tag;
    e.ea  = 64'(b + o);
    e.bad = u && !st && (bi == 0 || bi == rt);
    e.wb  = u && !e.bad && (bi != 0);
    e.wi  = bi;
    return e;
  endfunction

  task automatic compare(exp_t e);
    n_cmp++;
    if (ea_out !== e.ea || wb_en !== e.wb || wb_idx !== e.wi || bad_form !== e.bad) begin
      n_bad++;
      $display("FAIL %s: got ea=%h wb=%b idx=%0d bad=%b, expected ea=%h wb=%b idx=%0d bad=%b",
               e.tag, ea_out, wb_en, wb_idx, bad_form, e.ea, e.wb, e.wi, e.bad);
    end
  endtask

  // Drive at a falling edge; check the result of the previous drive first (R10 latency)
  task automatic step(string tag, logic [4:0] bi, logic [63:0] bv, logic [63:0] iv,
                      logic [15:0] im, logic [1:0] fm, logic u, logic [4:0] rt, logic st);
    @(negedge clk);
    if (exp_q.size() > 0) compare(exp_q.pop_front());
    base_idx = bi; base_val = bv; index_val = iv; imm_raw = im;
    form = fm; upd = u; rt_idx = rt; is_store = st;
    exp_q.push_back(model(tag, bi, bv, iv, im, fm, u, rt, st));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    exp_t z;
    repeat (3) @(posedge clk);
    @(negedge clk);
    z.tag = "R10_reset"; z.ea = '0; z.wb = 0; z.wi = '0; z.bad = 0;
    compare(z);
    rst = 1'b0;

    // R1: base field zero reads as zero for a non-update operation
    step("R1", 5'd0, 64'h1234, 64'h0, 16'h0010, 2'd0, 0, 5'd4, 0);
    step("R1", 5'd3, 64'h1000, 64'h0, 16'h0010, 2'd0, 0, 5'd4, 0);
    // R2: negative displacement sign extension
    step("R2", 5'd3, 64'h10000, 64'h0, 16'h8000, 2'd0, 0, 5'd4, 0);
    // R3: low two immediate bits ignored, -4 offset
    step("R3", 5'd3, 64'h100, 64'h0, 16'hFFFF, 2'd1, 0, 5'd4, 0);
    step("R3", 5'd3, 64'h100, 64'h0, 16'h0007, 2'd1, 0, 5'd4, 1);
    // R4: low four immediate bits ignored
    step("R4", 5'd3, 64'h100, 64'h0, 16'h001F, 2'd2, 0, 5'd4, 0);
    step("R4", 5'd0, 64'h5, 64'h0, 16'hFFFF, 2'd2, 0, 5'd4, 0);
    // R5: indexed form ignores the immediate
    step("R5", 5'd0, 64'h77, 64'hDEAD, 16'hFFFF, 2'd3, 0, 5'd4, 0);
    step("R5", 5'd9, 64'h100, 64'hFFFF_FFFF_FFFF_FF00, 16'h1234, 2'd3, 0, 5'd4, 1);
    // R6: update uses base value and writes back
    step("R6", 5'd5, 64'h2000, 64'h0, 16'h0008, 2'd0, 1, 5'd7, 0);
    step("R6", 5'd0, 64'h40, 64'h0, 16'h0004, 2'd1, 1, 5'd7, 1);
    step("R6", 5'd12, 64'h40, 64'h30, 16'h0, 2'd3, 1, 5'd2, 0);
    // R7: illegal load updates
    step("R7", 5'd0, 64'h40, 64'h0, 16'h0004, 2'd0, 1, 5'd7, 0);
    step("R7", 5'd6, 64'h40, 64'h0, 16'h0004, 2'd2, 1, 5'd6, 0);
    // R8: store update with source equal to base
    step("R8", 5'd6, 64'h40, 64'h8, 16'h0, 2'd3, 1, 5'd6, 1);
    // R9: wrap-around
    step("R9", 5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0002, 2'd0, 0, 5'd2, 0);
    step("R9", 5'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 16'h0, 2'd3, 1, 5'd2, 1);

    // Random mix across all requirements
    for (int i = 0; i < 400; i++) begin
      logic [4:0] bi, rt;
      bi = 5'($urandom_range(0, 7));
      rt = 5'($urandom_range(0, 7));
      step("R9_rand", bi, {$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom),
           2'($urandom), 1'($urandom), rt, 1'($urandom));
    end
    @(negedge clk);
    if (exp_q.size() > 0) compare(exp_q.pop_front());
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end
endmodule